// File: doc/BRIEF.md
# AES-128 Iterative Block Decryptor

This block turns one 128-bit AES-128 ciphertext into its plaintext. It uses a single state register and a single inverse-round datapath, so it completes one inverse round on each clock. The caller does not supply the cipher key. The caller supplies the final-round subkey, which is computed once elsewhere and kept for reuse. From that subkey the core derives the earlier subkeys on the fly, one per cycle, by running the key-expansion step in reverse. The subkeys are therefore consumed from the last to the first, with no key storage beyond one 128-bit register.

A one-cycle start pulse loads the ciphertext and the final subkey. Ten clocks later a one-cycle done pulse appears, and the recovered block is on the plaintext output at the same time. The plaintext output stays at that value until the next block completes.

The inverse column mixing has no dense inverse matrix of its own. It is a light pre-multiplication that needs only doublings and XORs, followed by the ordinary forward column-mixing network.

Top module: `aes128_dec_core`

## Requirements
- R1: While reset is high and in the first cycle after it, `done_o` is 0 and `pt_o` is all zeros.
- R2: Byte k of every 128-bit port sits at bits [8k+7:8k] and is the state cell at row k mod 4, column k div 4. With this packing, ciphertext 0x97ef6624f3ca9ea860367a0db47bd73a and final subkey 0xa60c63b6c80c3fe18925eec9a8f914d0 give plaintext 0x2a179373117e3de9969f402ee2bec16b.
- R3: A start that is accepted at clock edge E makes `done_o` high for exactly one cycle, starting after edge E+10.
- R4: A start asserted while a block is in progress is ignored. The running block's result and its completion cycle do not change.
- R5: For any cipher key and plaintext, the following holds. Take the block produced by forward encryption and the final subkey produced by forward key expansion. Feed both to the core, and it returns the original plaintext. This covers the reverse key steps, with round constants running 0x36, 0x1b, 0x80, 0x40 and onward down to 0x01.
- R6: `pt_o` changes only at the edge that raises `done_o`. Between completions it holds its value.
- R7: A start asserted in the cycle where `done_o` is high is accepted, so blocks can follow each other every 11 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin decrypting `ct_i` with `rkey_i` (ignored while busy) |
| rkey_i | input | 128 | Final-round (round 10) subkey |
| ct_i | input | 128 | Ciphertext block |
| pt_o | output | 128 | Recovered plaintext, registered, held between completions |
| done_o | output | 1 | One-cycle pulse when `pt_o` has been updated |

## Verification
The situation hardest to bring about is a start request that arrives mid-block. Such a request must be dropped, yet its inputs differ from the running block's, so it could corrupt the state or the key register. The bench raises start with a different block and key partway through a run. It then confirms that the first block's plaintext still arrives on the original cycle. A second pressure point is the edge between blocks. There, start is raised in the very cycle done is high, and the bench checks that the following block is taken without a lost cycle. A cycle-accurate behavioural model whose expected values come from an independent forward cipher is compared against `done_o` and `pt_o` on every clock.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int COLS   = 4;
  localparam int WORD_W = BYTE_W * 4;
  localparam int BLK_W  = WORD_W * COLS;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t gf_dbl(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc = '0;
    byte_t p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_dbl(p);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (zero maps to zero)
  function automatic byte_t gf_inv(byte_t a);
    byte_t a2, a3, a12, a15, a240;
    a2   = gf_mul(a, a);
    a3   = gf_mul(a2, a);
    a12  = gf_mul(gf_mul(a3, a3), gf_mul(a3, a3));
    a15  = gf_mul(a12, a3);
    a240 = gf_mul(a15, a15);
    a240 = gf_mul(a240, a240);
    a240 = gf_mul(a240, a240);
    a240 = gf_mul(a240, a240);
    return gf_mul(gf_mul(a240, a12), a2);
  endfunction

  function automatic byte_t sbox_fwd(byte_t x);
    byte_t b;
    b = gf_inv(x);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic byte_t sbox_inv(byte_t x);
    return gf_inv({x[6:0], x[7]} ^ {x[4:0], x[7:5]} ^ {x[1:0], x[7:2]} ^ 8'h05);
  endfunction

  // divide a round constant by x
  function automatic byte_t rc_half(byte_t x);
    return {1'b0, x[7:1]} ^ (x[0] ? 8'h8d : 8'h00);
  endfunction
endpackage

// File: rtl/aes_dec_mixcol.sv
module aes_dec_mixcol
  import aes_dec_pkg::*;
(
  input  word_t col_i,
  output word_t col_o
);
  byte_t a0, a1, a2, a3, u, v, p0, p1, p2, p3;

  always_comb begin
    a0 = col_i[7:0];
    a1 = col_i[15:8];
    a2 = col_i[23:16];
    a3 = col_i[31:24];
    // premultiply by 05 + 04*y^2: each byte picks up 4*(self ^ opposite)
    u  = gf_dbl(gf_dbl(a0 ^ a2));
    v  = gf_dbl(gf_dbl(a1 ^ a3));
    p0 = a0 ^ u;
    p1 = a1 ^ v;
    p2 = a2 ^ u;
    p3 = a3 ^ v;
    // forward column mixing
    col_o[7:0]   = gf_dbl(p0) ^ gf_dbl(p1) ^ p1 ^ p2 ^ p3;
    col_o[15:8]  = p0 ^ gf_dbl(p1) ^ gf_dbl(p2) ^ p2 ^ p3;
    col_o[23:16] = p0 ^ p1 ^ gf_dbl(p2) ^ gf_dbl(p3) ^ p3;
    col_o[31:24] = gf_dbl(p0) ^ p0 ^ p1 ^ p2 ^ gf_dbl(p3);
  end
endmodule

// File: rtl/aes_dec_round.sv
module aes_dec_round
  import aes_dec_pkg::*;
(
  input  blk_t state_i,
  input  blk_t rkey_i,
  input  logic last_i,
  output blk_t state_o
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    word_t ark_col;
    word_t mix_col;
    for (genvar r = 0; r < 4; r++) begin : g_row
      // row r is rotated right by r positions
      localparam int SRC = r + 4 * ((c - r + COLS) % COLS);
      localparam int DST = r + 4 * c;
      assign ark_col[BYTE_W*r +: BYTE_W] =
        sbox_inv(state_i[BYTE_W*SRC +: BYTE_W]) ^ rkey_i[BYTE_W*DST +: BYTE_W];
    end
    aes_dec_mixcol u_mix (
      .col_i (ark_col),
      .col_o (mix_col)
    );
    assign state_o[WORD_W*c +: WORD_W] = last_i ? ark_col : mix_col;
  end
endmodule

// File: rtl/aes_dec_keyrev.sv
module aes_dec_keyrev
  import aes_dec_pkg::*;
(
  input  blk_t  key_i,
  input  byte_t rcon_i,
  output blk_t  key_o
);
  word_t k [COLS];
  word_t w [COLS];
  word_t rot;
  word_t sub;

  for (genvar i = 0; i < COLS; i++) begin : g_split
    assign k[i] = key_i[WORD_W*i +: WORD_W];
  end

  for (genvar i = 1; i < COLS; i++) begin : g_chain
    assign w[i] = k[i] ^ k[i-1];
  end

  assign rot = {w[COLS-1][7:0], w[COLS-1][31:8]};

  for (genvar b = 0; b < 4; b++) begin : g_sub
    assign sub[BYTE_W*b +: BYTE_W] = sbox_fwd(rot[BYTE_W*b +: BYTE_W]);
  end

  assign w[0] = k[0] ^ sub ^ {24'h0, rcon_i};

  for (genvar i = 0; i < COLS; i++) begin : g_join
    assign key_o[WORD_W*i +: WORD_W] = w[i];
  end
endmodule

// File: rtl/aes128_dec_core.sv
module aes128_dec_core
  import aes_dec_pkg::*;
#(
  parameter int          NUM_ROUNDS = 10,
  parameter logic [7:0]  RCON_INIT  = 8'h36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [127:0] rkey_i,
  input  logic [127:0] ct_i,
  output logic [127:0] pt_o,
  output logic         done_o
);
  localparam int CNT_W = $clog2(NUM_ROUNDS);
  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(NUM_ROUNDS - 1);

  blk_t             state_q, key_q, pt_q;
  byte_t            rcon_q;
  logic [CNT_W-1:0] rnd_q;
  logic             busy_q, done_q;
  blk_t             prev_key, rnd_out;
  logic             last_rnd;

  assign last_rnd = (rnd_q == LAST_RND);

  aes_dec_keyrev u_keyrev (
    .key_i  (key_q),
    .rcon_i (rcon_q),
    .key_o  (prev_key)
  );

  aes_dec_round u_round (
    .state_i (state_q),
    .rkey_i  (prev_key),
    .last_i  (last_rnd),
    .state_o (rnd_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      key_q   <= '0;
      pt_q    <= '0;
      rcon_q  <= '0;
      rnd_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        state_q <= rnd_out;
        key_q   <= prev_key;
        rcon_q  <= rc_half(rcon_q);
        rnd_q   <= rnd_q + 1'b1;
        if (last_rnd) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pt_q   <= rnd_out;
          rnd_q  <= '0;
        end
      end else if (start_i) begin
        state_q <= ct_i ^ rkey_i;
        key_q   <= rkey_i;
        rcon_q  <= RCON_INIT;
        rnd_q   <= '0;
        busy_q  <= 1'b1;
      end
    end
  end

  assign pt_o   = pt_q;
  assign done_o = done_q;
endmodule

// File: rtl/aes128_dec_core_chk.sv
module aes128_dec_core_chk #(
  parameter int NUM_ROUNDS = 10,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy,
  input logic [CNT_W-1:0] rnd,
  input logic [127:0]     pt_o,
  input logic             done_o
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_after_run_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy));

  assert_quiet_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done_o);

  assert_round_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rnd < CNT_W'(NUM_ROUNDS)));

  assert_launch_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy) |=> busy);

  assert_busy_start_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && rnd != CNT_W'(NUM_ROUNDS - 1)) |=> (busy && rnd == $past(rnd) + 1'b1));

  assert_pt_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(pt_o));
endmodule

bind aes128_dec_core aes128_dec_core_chk #(
  .NUM_ROUNDS (NUM_ROUNDS),
  .CNT_W      (CNT_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy    (busy_q),
  .rnd     (rnd_q),
  .pt_o    (pt_o),
  .done_o  (done_o)
);

// File: tb/aes128_dec_core_tb_top.sv
`timescale 1ns/1ps
module aes128_dec_core_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [127:0] rkey_i = '0;
  logic [127:0] ct_i = '0;
  logic [127:0] pt_o;
  logic         done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  aes128_dec_core dut_i (
    .clk (clk), .rst (rst), .start_i (start_i), .rkey_i (rkey_i),
    .ct_i (ct_i), .pt_o (pt_o), .done_o (done_o)
  );

  // ---------------- independent forward reference ----------------
  logic [7:0] sb [256];

  function automatic logic [7:0] r_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] bb  = b;
    for (int i = 0; i < 8; i++) begin
      if (a[i]) acc = acc ^ bb;
      bb = bb[7] ? ((bb << 1) ^ 8'h1b) : (bb << 1);
    end
    return acc;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (x != 0 && r_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      s = 8'h63;
      for (int k = 0; k < 5; k++) s = s ^ ((inv << k) | (inv >> (8 - k)));
      sb[x] = s;
    end
  endtask

  function automatic logic [31:0] r_subword(logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [127:0] r_encrypt(logic [127:0] p, logic [127:0] key,
                                             output logic [127:0] last_key);
    logic [31:0]  w [44];
    logic [127:0] s, t;
    logic [7:0]   rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[32*i +: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = r_subword({tmp[7:0], tmp[31:8]}) ^ {24'h0, rc};
        rc  = r_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ tmp;
    end
    s = p ^ {w[3], w[2], w[1], w[0]};
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          t[8*(r+4*c) +: 8] = sb[s[8*(r+4*((c+r)%4)) +: 8]];
      if (rnd != 10) begin
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a0, a1, a2, a3;
          a0 = t[32*c +: 8]; a1 = t[32*c+8 +: 8];
          a2 = t[32*c+16 +: 8]; a3 = t[32*c+24 +: 8];
          t[32*c +: 8]    = r_mul(2, a0) ^ r_mul(3, a1) ^ a2 ^ a3;
          t[32*c+8 +: 8]  = a0 ^ r_mul(2, a1) ^ r_mul(3, a2) ^ a3;
          t[32*c+16 +: 8] = a0 ^ a1 ^ r_mul(2, a2) ^ r_mul(3, a3);
          t[32*c+24 +: 8] = r_mul(3, a0) ^ a1 ^ a2 ^ r_mul(2, a3);
        end
      end
      s = t ^ {w[4*rnd+3], w[4*rnd+2], w[4*rnd+1], w[4*rnd]};
    end
    last_key = {w[43], w[42], w[41], w[40]};
    return s;
  endfunction

  // ---------------- cycle model ----------------
  logic [127:0] drv_exp = '0;
  logic [127:0] m_exp = '0;
  logic [127:0] m_pt = '0;
  logic         m_done = 1'b0;
  logic         m_busy = 1'b0;
  int           m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_pt = '0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 1'b0; m_done = 1'b1; m_pt = m_exp;
        end
      end else if (start_i) begin
        m_busy = 1'b1; m_cnt = 10; m_exp = drv_exp;
      end
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R3 timing, R6 hold, R5 values)
  always @(negedge clk) begin
    if (!rst) begin
      check(done_o == m_done, "R3 done timing", {127'h0, done_o}, {127'h0, m_done});
      check(pt_o == m_pt, "R6 plaintext vs model", pt_o, m_pt);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive_now(input logic [127:0] p, input logic [127:0] k);
    logic [127:0] c, k10;
    c = r_encrypt(p, k, k10);
    start_i = 1'b1; ct_i = c; rkey_i = k10; drv_exp = p;
  endtask

  task automatic count_to_done(output int n);
    n = 0;
    while (!done_o && n < 40) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic run_block(input logic [127:0] p, input logic [127:0] k, input string req);
    int n;
    @(negedge clk); drive_now(p, k);
    @(negedge clk); start_i = 1'b0;
    count_to_done(n);
    check(n == 10, "R3 latency", 128'(n), 128'd10);
    check(pt_o == p, req, pt_o, p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [127:0] pa, pb, ka, kb;
    build_sbox();
    repeat (4) @(negedge clk);
    check(done_o == 1'b0, "R1 reset done", {127'h0, done_o}, 128'h0);
    check(pt_o == '0, "R1 reset plaintext", pt_o, 128'h0);
    rst = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0 && pt_o == '0, "R1 after reset", pt_o, 128'h0);

    // R2: known answer with hard-coded final subkey and block
    start_i = 1'b1;
    ct_i    = 128'h97ef6624f3ca9ea860367a0db47bd73a;
    rkey_i  = 128'ha60c63b6c80c3fe18925eec9a8f914d0;
    drv_exp = 128'h2a179373117e3de9969f402ee2bec16b;
    @(negedge clk); start_i = 1'b0;
    count_to_done(n);
    check(n == 10, "R3 latency known", 128'(n), 128'd10);
    check(pt_o == 128'h2a179373117e3de9969f402ee2bec16b, "R2 known vector",
          pt_o, 128'h2a179373117e3de9969f402ee2bec16b);

    // R6: hold with start low
    repeat (15) @(negedge clk);
    check(pt_o == 128'h2a179373117e3de9969f402ee2bec16b, "R6 hold",
          pt_o, 128'h2a179373117e3de9969f402ee2bec16b);

    // R4: start with another block during a run
    pa = {$urandom, $urandom, $urandom, $urandom};
    ka = {$urandom, $urandom, $urandom, $urandom};
    pb = {$urandom, $urandom, $urandom, $urandom};
    kb = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk); drive_now(pa, ka);
    @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    drive_now(pb, kb);
    @(negedge clk);
    @(negedge clk); start_i = 1'b0;
    count_to_done(n);
    check(n == 5, "R4 completion cycle unchanged", 128'(n), 128'd5);
    check(pt_o == pa, "R4 busy start ignored", pt_o, pa);

    // R7: back-to-back start in the done cycle
    drive_now(pb, kb);
    @(negedge clk); start_i = 1'b0;
    count_to_done(n);
    check(n == 10, "R7 back-to-back latency", 128'(n), 128'd10);
    check(pt_o == pb, "R7 back-to-back result", pt_o, pb);

    // R5: assorted keys and blocks, including extremes
    run_block('0, '0, "R5 zero key zero block");
    run_block('1, '1, "R5 ones key ones block");
    for (int i = 0; i < 8; i++)
      run_block({$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom}, "R5 random vector");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule